// File: doc/BRIEF.md
# Packed-Parameter Raster Timing Generator

This block produces the horizontal and vertical scan timing of a display controller. A host loads eight parameter bytes through a small write port. Character counts, line counts and the lengths of sync and porch intervals are packed as bit fields inside those bytes. The block decodes the fields and drives two segment state machines: one advances every character clock, the other advances once per finished line. From their states it drives horizontal and vertical sync, two blanking flags that a status byte can report, and a single-cycle vertical-blank interrupt. That interrupt fires only when the host has armed it beforehand.

Host writes land in a holding copy of the parameters. The holding copy moves into the live copy on the cycle that wraps the frame, so a frame never mixes old and new timing.

The horizontal machine has four states: `H_ACTIVE`, `H_FRONT`, `H_SYNC` and `H_BACK`. It always steps through them in that order. It leaves a state when the count of cycles spent there reaches that state's length, and it returns from `H_BACK` to `H_ACTIVE` at the end of the line.

The vertical machine has four states: `V_ACTIVE`, `V_FRONT`, `V_SYNC` and `V_BACK`. It moves only at line ends. On leaving a state it goes to the next state in that order whose length is non-zero. `V_BACK` always returns to `V_ACTIVE`. The step from `V_ACTIVE` into blanking is the interrupt point. The step back into `V_ACTIVE` is the frame wrap, and the live parameters load there.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, every output is low and the live and holding bytes 0..7 are 10 4E 07 25 07 07 90 65 (hex). This gives 80 active characters, a 106-cycle line, 400 active lines, so vblank first rises 42400 cycles after reset.
- R2: Each line starts with (byte 1 + 2) active character clocks, during which hblank is low. hblank is high for every other cycle of the line.
- R3: Bytes 2 (low) and 3 (high) form word A. Bits 4:0 of A are SW, bits 15:10 are HF. Bits 5:0 of byte 4 are HB. After the active part, the line has HF+1 front cycles, then SW+1 sync cycles, then HB+1 back cycles. The line length is therefore active + SW + HF + HB + 3.
- R4: hsync is high exactly during the SW+1 sync cycles, and only while hblank is high.
- R5: Bytes 6 (low) and 7 (high) form word B. The active line count is ((B − 1) AND 0x3FF) + 1, so a low field of 0 means 1024 lines. vblank is low on active lines and high on every later line until the frame wraps.
- R6: After the active lines come VF lines of front porch (byte 5 bits 5:0), then VS lines of sync (bits 9:5 of word A), then VB lines of back porch (bits 15:10 of word B). vsync is high exactly on the sync lines.
- R7: When VF + VS + VB is zero, the frame still has exactly one blank line, and vsync stays low.
- R8: vblank changes only on the first cycle of a line, a cycle in which hblank is low.
- R9: A write (enable high, select 0..7, data) updates the holding byte on the next edge. The live timing changes only at the edge that wraps the frame, so a write in mid-frame leaves the current frame's timing unchanged.
- R10: A one-cycle pulse on the arm input enables exactly one interrupt. The interrupt is a one-cycle pulse on the first cycle in which vblank is high, and issuing it clears the arm.
- R11: No interrupt is issued while the block is not armed. An arm pulse on the very cycle before an interrupt leaves the block armed for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prm_we | input | 1 | Parameter write strobe |
| prm_sel | input | 3 | Parameter byte index 0..7 |
| prm_data | input | 8 | Parameter byte value |
| irq_arm_wr | input | 1 | Arms one vertical-blank interrupt |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| hblank | output | 1 | Horizontal blanking flag |
| vblank | output | 1 | Vertical blanking flag |
| vsync_irq | output | 1 | One-cycle vertical-blank interrupt |

## Verification
On every cycle, the assertions check the following relations:
- Each sync lies inside its blanking flag.
- vblank moves only at the start of a line.
- The interrupt is one cycle wide, lands on the rising edge of vblank, needs a prior arm, and consumes that arm.

The bench's scenarios cover what no single-cycle relation can show: the decoded lengths themselves. These are the line and frame periods, the blank and sync widths for several packed parameter sets, the forced single blank line, the 1024-line wrap of the active count, the deferral of writes to the frame wrap, and the re-arm that coincides with an interrupt.

// File: rtl/raster_pkg.sv
`timescale 1ns/1ps
package raster_pkg;
    localparam int NPRM      = 8;
    localparam int PRM_IDX_W = $clog2(NPRM);
    localparam int PRM_BITS  = NPRM * 8;

    // byte i sits at bits [i*8 +: 8]
    localparam logic [PRM_BITS-1:0] PRM_RESET = 64'h6590_0707_2507_4E10;

    typedef enum logic [1:0] {H_ACTIVE, H_FRONT, H_SYNC, H_BACK} hstate_e;
    typedef enum logic [1:0] {V_ACTIVE, V_FRONT, V_SYNC, V_BACK} vstate_e;
endpackage

// File: rtl/sync_param_bank.sv
`timescale 1ns/1ps
module sync_param_bank
    import raster_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PRM_IDX_W-1:0] wr_sel,
    input  logic [7:0]           wr_data,
    input  logic                 load,
    output logic [PRM_BITS-1:0]  live_flat
);
    logic [7:0] held [NPRM];
    logic [7:0] live [NPRM];

    for (genvar i = 0; i < NPRM; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held[i] <= PRM_RESET[i*8 +: 8];
                live[i] <= PRM_RESET[i*8 +: 8];
            end else begin
                if (wr_en && (wr_sel == PRM_IDX_W'(i))) begin
                    held[i] <= wr_data;
                end
                if (load) begin
                    live[i] <= held[i];
                end
            end
        end
        assign live_flat[i*8 +: 8] = live[i];
    end
endmodule

// File: rtl/raster_hfsm.sv
`timescale 1ns/1ps
module raster_hfsm
    import raster_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] len_act,
    input  logic [CW-1:0] len_front,
    input  logic [CW-1:0] len_sync,
    input  logic [CW-1:0] len_back,
    output hstate_e       state,
    output logic          line_end
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] cur_len;
    logic          last;
    hstate_e       nxt;

    always_comb begin
        unique case (state)
            H_ACTIVE: begin cur_len = len_act;   nxt = H_FRONT;  end
            H_FRONT:  begin cur_len = len_front; nxt = H_SYNC;   end
            H_SYNC:   begin cur_len = len_sync;  nxt = H_BACK;   end
            H_BACK:   begin cur_len = len_back;  nxt = H_ACTIVE; end
        endcase
        last     = (cnt + CW'(1)) >= cur_len;
        line_end = last && (state == H_BACK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= H_ACTIVE;
            cnt   <= '0;
        end else if (last) begin
            state <= nxt;
            cnt   <= '0;
        end else begin
            cnt   <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/raster_vfsm.sv
`timescale 1ns/1ps
module raster_vfsm
    import raster_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [CW-1:0] len_act,
    input  logic [CW-1:0] len_front,
    input  logic [CW-1:0] len_sync,
    input  logic [CW-1:0] len_back,
    output vstate_e       state,
    output logic          frame_end,
    output logic          blank_start
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] cur_len;
    logic          leave;
    vstate_e       nxt;

    always_comb begin
        unique case (state)
            V_ACTIVE: begin
                cur_len = len_act;
                nxt = (len_front != '0) ? V_FRONT :
                      (len_sync  != '0) ? V_SYNC  : V_BACK;
            end
            V_FRONT: begin
                cur_len = len_front;
                nxt = (len_sync != '0) ? V_SYNC :
                      (len_back != '0) ? V_BACK : V_ACTIVE;
            end
            V_SYNC: begin
                cur_len = len_sync;
                nxt = (len_back != '0) ? V_BACK : V_ACTIVE;
            end
            V_BACK: begin
                cur_len = len_back;
                nxt = V_ACTIVE;
            end
        endcase
        leave       = step && ((cnt + CW'(1)) >= cur_len);
        frame_end   = leave && (nxt == V_ACTIVE);
        blank_start = leave && (state == V_ACTIVE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= V_ACTIVE;
            cnt   <= '0;
        end else if (leave) begin
            state <= nxt;
            cnt   <= '0;
        end else if (step) begin
            cnt   <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/raster_vsync_irq.sv
`timescale 1ns/1ps
module raster_vsync_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_wr,
    input  logic blank_start,
    output logic armed,
    output logic irq
);
    logic fire;

    always_comb fire = blank_start && armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            irq   <= 1'b0;
        end else begin
            armed <= arm_wr || (armed && !fire);
            irq   <= fire;
        end
    end
endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int H_CNT_W = 10,
    parameter int V_CNT_W = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prm_we,
    input  logic [2:0] prm_sel,
    input  logic [7:0] prm_data,
    input  logic       irq_arm_wr,
    output logic       hsync,
    output logic       vsync,
    output logic       hblank,
    output logic       vblank,
    output logic       vsync_irq
);
    localparam int LINE_FIELD_W = 10;

    logic [PRM_BITS-1:0]     prm;
    logic [15:0]             word_a;
    logic [15:0]             word_b;
    logic [LINE_FIELD_W-1:0] lines_m1;
    logic [H_CNT_W-1:0]      h_act, h_front, h_sync, h_back;
    logic [V_CNT_W-1:0]      v_act, v_front, v_sync, v_back_raw, v_back;
    hstate_e                 h_state;
    vstate_e                 v_state;
    logic                    line_end, frame_end, blank_start;
    logic                    irq_armed;
    logic                    unused_prm_bits;

    sync_param_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (prm_we),
        .wr_sel    (PRM_IDX_W'(prm_sel)),
        .wr_data   (prm_data),
        .load      (frame_end),
        .live_flat (prm)
    );

    // field decode from the live bytes
    always_comb begin
        word_a     = {prm[31:24], prm[23:16]};
        word_b     = {prm[63:56], prm[55:48]};
        h_act      = H_CNT_W'(prm[15:8]) + H_CNT_W'(2);
        h_front    = H_CNT_W'(word_a[15:10]) + H_CNT_W'(1);
        h_sync     = H_CNT_W'(word_a[4:0]) + H_CNT_W'(1);
        h_back     = H_CNT_W'(prm[37:32]) + H_CNT_W'(1);
        lines_m1   = word_b[LINE_FIELD_W-1:0] - LINE_FIELD_W'(1);
        v_act      = V_CNT_W'(lines_m1) + V_CNT_W'(1);
        v_front    = V_CNT_W'(prm[45:40]);
        v_sync     = V_CNT_W'(word_a[9:5]);
        v_back_raw = V_CNT_W'(word_b[15:10]);
        if ((v_front == '0) && (v_sync == '0) && (v_back_raw == '0)) begin
            v_back = V_CNT_W'(1);
        end else begin
            v_back = v_back_raw;
        end
    end

    assign unused_prm_bits = ^{prm[7:0], prm[39:38], prm[47:46]};

    raster_hfsm #(.CW(H_CNT_W)) u_hfsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_act   (h_act),
        .len_front (h_front),
        .len_sync  (h_sync),
        .len_back  (h_back),
        .state     (h_state),
        .line_end  (line_end)
    );

    raster_vfsm #(.CW(V_CNT_W)) u_vfsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (line_end),
        .len_act     (v_act),
        .len_front   (v_front),
        .len_sync    (v_sync),
        .len_back    (v_back),
        .state       (v_state),
        .frame_end   (frame_end),
        .blank_start (blank_start)
    );

    raster_vsync_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_wr      (irq_arm_wr),
        .blank_start (blank_start),
        .armed       (irq_armed),
        .irq         (vsync_irq)
    );

    always_comb begin
        hblank = (h_state != H_ACTIVE);
        hsync  = (h_state == H_SYNC);
        vblank = (v_state != V_ACTIVE);
        vsync  = (v_state == V_SYNC);
    end
endmodule

// File: rtl/raster_timing_chk.sv
`timescale 1ns/1ps
module raster_timing_chk (
    input logic clk,
    input logic rst_n,
    input logic hsync,
    input logic vsync,
    input logic hblank,
    input logic vblank,
    input logic vsync_irq,
    input logic irq_arm_wr,
    input logic armed
);
    p_hsync_in_hblank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> hblank) else $error("hsync outside hblank");

    p_vsync_in_vblank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> vblank) else $error("vsync outside vblank");

    p_vblank_line_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vblank) |-> !hblank) else $error("vblank moved mid-line");

    p_vblank_after_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vblank) |-> $past(hblank)) else $error("vblank rose without line end");

    p_irq_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_irq |=> !vsync_irq) else $error("interrupt wider than one cycle");

    p_irq_on_vblank_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_irq |-> $rose(vblank)) else $error("interrupt not at vblank rise");

    p_irq_needs_arm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_irq |-> $past(armed)) else $error("interrupt without arm");

    p_irq_clears_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_irq && !$past(irq_arm_wr)) |-> !armed) else $error("arm kept after interrupt");
endmodule

bind raster_timing_gen raster_timing_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsync      (hsync),
    .vsync      (vsync),
    .hblank     (hblank),
    .vblank     (vblank),
    .vsync_irq  (vsync_irq),
    .irq_arm_wr (irq_arm_wr),
    .armed      (irq_armed)
);

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prm_we = 1'b0;
    logic [2:0] prm_sel = '0;
    logic [7:0] prm_data = '0;
    logic       irq_arm_wr = 1'b0;
    logic       hsync, vsync, hblank, vblank, vsync_irq;

    always #2 clk = ~clk;

    raster_timing_gen u_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .prm_we(prm_we), .prm_sel(prm_sel),
        .prm_data(prm_data), .irq_arm_wr(irq_arm_wr), .hsync(hsync),
        .vsync(vsync), .hblank(hblank), .vblank(vblank), .vsync_irq(vsync_irq)
    );

    int n_chk = 0, n_bad = 0;
    bit run = 0, done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // ---------------- behavioural reference ----------------
    int rst_b [8] = '{16, 78, 7, 37, 7, 7, 144, 101};
    int sh [8];
    int ac [8];
    int hpos, vpos;
    bit m_armed, m_irq;

    function automatic int wa();     return ac[2] + ac[3] * 256; endfunction
    function automatic int wb();     return ac[6] + ac[7] * 256; endfunction
    function automatic int act_ch(); return ac[1] + 2; endfunction
    function automatic int hs();     return wa() % 32; endfunction
    function automatic int vs();     return (wa() / 32) % 32; endfunction
    function automatic int hfp();    return wa() / 1024; endfunction
    function automatic int hbp();    return ac[4] % 64; endfunction
    function automatic int vfp();    return ac[5] % 64; endfunction
    function automatic int vbp();    return wb() / 1024; endfunction
    function automatic int act_ln(); return ((wb() + 1023) % 1024) + 1; endfunction
    function automatic int htot();   return act_ch() + hs() + hfp() + hbp() + 3; endfunction
    function automatic int vtot();
        int b;
        b = vs() + vfp() + vbp();
        if (b == 0) b = 1;
        return act_ln() + b;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin sh[i] = rst_b[i]; ac[i] = rst_b[i]; end
            hpos = 0; vpos = 0; m_armed = 0; m_irq = 0;
        end else begin
            int ht, vt, al;
            bit le, fe, fire;
            ht = htot(); vt = vtot(); al = act_ln();
            le = (hpos == ht - 1);
            fe = le && (vpos == vt - 1);
            fire = le && (vpos == al - 1) && m_armed;
            if (le) begin
                hpos = 0;
                vpos = fe ? 0 : vpos + 1;
            end else begin
                hpos = hpos + 1;
            end
            if (fe) for (int i = 0; i < 8; i++) ac[i] = sh[i];
            if (prm_we) sh[prm_sel] = prm_data;
            m_armed = irq_arm_wr || (m_armed && !fire);
            m_irq = fire;
        end
    end

    // ---------------- per-cycle compare and measurements ----------------
    int cyc = 0, hs_last = 0, hs_period = 0, vb_last = 0, vb_period = 0, vb_first = -1;
    int vb_run = 0, vs_run = 0, vb_len = 0, vs_len = 0, irq_cnt = 0;
    bit p_hs = 0, p_vb = 0;

    always @(negedge clk) begin
        if (run && !done) begin
            int s;
            cyc++;
            chk("R2 hblank", hblank, hpos >= act_ch());
            s = act_ch() + hfp() + 1;
            chk("R4 hsync", hsync, (hpos >= s) && (hpos < s + hs() + 1));
            chk("R5 vblank", vblank, vpos >= act_ln());
            s = act_ln() + vfp();
            chk("R6 vsync", vsync, (vpos >= s) && (vpos < s + vs()));
            chk("R10 vsync_irq", vsync_irq, m_irq);
            if (hsync && !p_hs) begin hs_period = cyc - hs_last; hs_last = cyc; end
            if (vblank && !p_vb) begin
                vb_period = cyc - vb_last; vb_last = cyc;
                if (vb_first < 0) vb_first = cyc;
                vb_run = 0; vs_run = 0;
            end
            if (vblank) vb_run++;
            if (vsync) vs_run++;
            if (!vblank && p_vb) begin vb_len = vb_run; vs_len = vs_run; end
            if (vblank != p_vb) chk("R8 hblank at vblank change", hblank, 0);
            if (vsync_irq) irq_cnt++;
            p_hs = hsync; p_vb = vblank;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input int idx, input logic [7:0] d);
        @(negedge clk);
        prm_we = 1; prm_sel = idx[2:0]; prm_data = d;
        @(negedge clk);
        prm_we = 0;
    endtask

    task automatic load_cfg(input logic [63:0] cfg);
        for (int i = 0; i < 8; i++) wr(i, cfg[i*8 +: 8]);
    endtask

    task automatic arm();
        @(negedge clk); irq_arm_wr = 1;
        @(negedge clk); irq_arm_wr = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset hsync", hsync, 0);
        chk("R1 reset vsync", vsync, 0);
        chk("R1 reset hblank", hblank, 0);
        chk("R1 reset vblank", vblank, 0);
        chk("R1 reset irq", vsync_irq, 0);
        rst_n = 1;
        @(posedge clk);
        run = 1;
        arm();
        wait_cyc(300);
        chk("R1 default line period", hs_period, 106);
        load_cfg(64'h0405_0101_0841_0600);
        wait_cyc(300);
        chk("R9 line period unchanged before wrap", hs_period, 106);
        while (cyc < 46700) @(negedge clk);
        chk("R1 first vblank cycle", vb_first, 42400);
        chk("R10 one interrupt per arm", irq_cnt, 1);
        wait_cyc(400);
        chk("R3 line period cfg A", hs_period, 15);
        chk("R6 frame period cfg A", vb_period, 135);
        chk("R6 vsync cycles cfg A", vs_len, 30);
        chk("R5 vblank cycles cfg A", vb_len, 60);
        chk("R11 no interrupt unarmed", irq_cnt, 1);
        irq_cnt = 0;
        arm();
        while (!(m_armed && (hpos == htot() - 1) && (vpos == act_ln() - 1))) @(negedge clk);
        irq_arm_wr = 1;
        @(negedge clk);
        irq_arm_wr = 0;
        wait_cyc(200);
        chk("R11 re-arm at interrupt keeps arm", irq_cnt, 2);
        wait_cyc(400);
        chk("R10 arm consumed", irq_cnt, 2);
        load_cfg(64'h0003_0000_0000_0200);
        wait_cyc(400);
        chk("R7 single blank line", vb_len, 7);
        chk("R7 no vsync", vs_len, 0);
        chk("R7 frame period cfg B", vb_period, 28);
        chk("R3 line period cfg B", hs_period, 7);
        load_cfg(64'h0000_0000_0000_0000);
        wait_cyc(10500);
        chk("R5 1024-line frame period", vb_period, 5125);
        chk("R5 blank cycles cfg C", vb_len, 5);
        chk("R2 line period cfg C", hs_period, 5);
        report();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        report();
    end
endmodule